// File: doc/BRIEF.md
# Low-Voltage Inhibit Filter Controller

This block is the digital half of a supply supervisor. Two comparator outputs arrive from the analog side: one says the supply is at or below the falling trip level, the other says it is above the rising trip level. The block synchronizes both signals and filters them on two independent time bases. A short filter, clocked by a CPU-cycle enable, produces a hysteretic system reset request. A longer filter, clocked by an oscillator-cycle enable, produces a read-only low-supply flag. Software can poll that flag through a byte-wide read port.

Configuration inputs enable the block, enable reset generation, and keep the block alive in stop mode. In stop mode the CPU-cycle enable no longer pulses. The raw falling-trip input can then bypass both filters and raise the reset request directly, with no clock needed. With reset generation turned off, the block runs in polled mode and only updates the flag. The block never raises an interrupt.

Top module: `lvi_ctrl`

## Requirements
- R1: When the synchronized below-trip input is high on nine consecutive CPU-enabled cycles, the reset request rises at the clock edge of the ninth. Any CPU-enabled cycle with the synchronized below-trip input low restarts the count.
- R2: Once the reset request is high, a single CPU-enabled cycle with the synchronized above-trip input high drops it at that edge. While no CPU-enabled cycle occurs, the request stays high.
- R3: With reset-enable at 0, no filtered reset request is ever raised, and the flag still operates.
- R4: The flag sets at the edge of the 36th consecutive oscillator-enabled cycle with the synchronized below-trip input high. It stays 0 after 35 such cycles.
- R5: The flag clears on any clock edge where the synchronized above-trip input is high, whether or not the oscillator enable is high. While neither comparator input is high, the flag keeps its value.
- R6: Asserting rst_ni clears the flag and the reset request.
- R7: When stop_i, enable and stop-enable are all 1, the raw below-trip input drives rst_req_o high in the same cycle, without any clock edge.
- R8: The block is inactive when enable is 0, or when stop_i is 1 with stop-enable at 0. While inactive, no filter advances, no reset request is raised and the flag does not set.
- R9: rd_data_o carries the flag in bit 7, and bits 6 to 0 always read 0. The port has no write path.
- R10: The two filters count independently. When the ninth CPU-enabled cycle and the 36th oscillator-enabled cycle land on the same edge, the reset request and the flag rise together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_en_i | input | 1 | CPU-cycle clock enable |
| osc_en_i | input | 1 | Oscillator-cycle clock enable |
| below_fall_i | input | 1 | Comparator: supply at or below falling trip level (asynchronous) |
| above_rise_i | input | 1 | Comparator: supply above rising trip level (asynchronous) |
| cfg_en_i | input | 1 | Block enable |
| cfg_rst_en_i | input | 1 | Reset generation enable |
| cfg_stop_en_i | input | 1 | Stay active in stop mode |
| stop_i | input | 1 | Stop mode indicator |
| rst_req_o | output | 1 | System reset request |
| rd_data_o | output | 8 | Status register read data |

## Verification
The filtered reset request and the flag set can fall on the same clock edge. The bench provokes this by pulsing the CPU enable every fourth cycle and the oscillator enable on every cycle. The ninth CPU pulse and the 36th oscillator pulse then coincide. Both outputs are sampled one cycle before that edge, where both must still be 0, and again just after it, where both must be 1. A second overlap occurs when the above-trip input returns: the flag must clear even with no oscillator enable, while the reset request waits for a CPU-enabled cycle.

// File: rtl/lvi_pkg.sv
package lvi_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_STOP = 2'd2
  } lvi_mode_e;

  localparam int unsigned RD_W     = 8;
  localparam int unsigned FLAG_BIT = 7;
endpackage

// File: rtl/lvi_sync.sv
module lvi_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/lvi_sat_filt.sv
module lvi_sat_filt #(
  parameter int unsigned TRIP = 9,
  parameter int unsigned CW   = $clog2(TRIP + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  input  logic sample_i,
  output logic hit_o
);
  localparam logic [CW-1:0] SAT     = {CW{1'b1}};
  localparam logic [CW-1:0] TRIP_M1 = CW'(TRIP - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (tick_i && !sample_i)    cnt_q <= '0;
    else if (tick_i && cnt_q != SAT) cnt_q <= cnt_q + 1'b1;
  end

  // this tick completes the TRIP-th consecutive sample
  assign hit_o = !clr_i && tick_i && sample_i && (cnt_q >= TRIP_M1);
endmodule

// File: rtl/lvi_ctrl.sv
module lvi_ctrl
  import lvi_pkg::*;
#(
  parameter int unsigned CPU_TRIP = 9,
  parameter int unsigned OSC_TRIP = 36,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cpu_en_i,
  input  logic            osc_en_i,
  input  logic            below_fall_i,
  input  logic            above_rise_i,
  input  logic            cfg_en_i,
  input  logic            cfg_rst_en_i,
  input  logic            cfg_stop_en_i,
  input  logic            stop_i,
  output logic            rst_req_o,
  output logic [RD_W-1:0] rd_data_o
);
  logic [1:0] cmp_s;
  logic       below_s, above_s;
  lvi_mode_e  mode;
  logic       active, bypass;
  logic       cpu_hit, osc_hit;
  logic       rst_q, flag_q;

  lvi_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({above_rise_i, below_fall_i}),
    .q_o    (cmp_s)
  );
  assign below_s = cmp_s[0];
  assign above_s = cmp_s[1];

  always_comb begin
    if (!cfg_en_i)                   mode = MODE_OFF;
    else if (stop_i && cfg_stop_en_i) mode = MODE_STOP;
    else if (stop_i)                 mode = MODE_OFF;
    else                             mode = MODE_RUN;
  end

  assign active = (mode != MODE_OFF);
  // unfiltered path: CPU clock is halted in stop
  assign bypass = (mode == MODE_STOP) && below_fall_i;

  lvi_sat_filt #(.TRIP(CPU_TRIP)) u_cpu_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!active),
    .tick_i   (cpu_en_i),
    .sample_i (below_s),
    .hit_o    (cpu_hit)
  );

  lvi_sat_filt #(.TRIP(OSC_TRIP)) u_osc_filt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!active),
    .tick_i   (osc_en_i),
    .sample_i (below_s),
    .hit_o    (osc_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     rst_q <= 1'b0;
    else if (!active || !cfg_rst_en_i) rst_q <= 1'b0;
    else if (cpu_en_i && above_s)    rst_q <= 1'b0;
    else if (cpu_hit)                rst_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (above_s) flag_q <= 1'b0;
    else if (osc_hit) flag_q <= 1'b1;
  end

  assign rst_req_o = rst_q | bypass;

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[FLAG_BIT] = flag_q;
  end
endmodule

// File: rtl/lvi_ctrl_chk.sv
module lvi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cpu_en_i,
  input logic       osc_en_i,
  input logic       below_fall_i,
  input logic       cfg_en_i,
  input logic       cfg_rst_en_i,
  input logic       cfg_stop_en_i,
  input logic       stop_i,
  input logic       rst_req_o,
  input logic [7:0] rd_data_o,
  input logic       rst_q,
  input logic       flag_q,
  input logic       above_s
);
  AST_RD_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[6:0] == 7'd0); // R9

  AST_RST_SET_ON_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_q) |-> $past(cpu_en_i && cfg_rst_en_i && cfg_en_i)); // R1

  AST_RST_REL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_q) |-> $past(cpu_en_i && above_s) ||
                     $past(!cfg_en_i || !cfg_rst_en_i || (stop_i && !cfg_stop_en_i))); // R2

  AST_FLAG_CLR_ABOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    above_s |=> !flag_q); // R5

  AST_FLAG_SET_ON_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(osc_en_i)); // R4

  AST_FLAG_BIT_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[7] == flag_q); // R9

  AST_STOP_BYPASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && cfg_en_i && cfg_stop_en_i && below_fall_i) |-> rst_req_o); // R7
endmodule

bind lvi_ctrl lvi_ctrl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cpu_en_i      (cpu_en_i),
  .osc_en_i      (osc_en_i),
  .below_fall_i  (below_fall_i),
  .cfg_en_i      (cfg_en_i),
  .cfg_rst_en_i  (cfg_rst_en_i),
  .cfg_stop_en_i (cfg_stop_en_i),
  .stop_i        (stop_i),
  .rst_req_o     (rst_req_o),
  .rd_data_o     (rd_data_o),
  .rst_q         (rst_q),
  .flag_q        (flag_q),
  .above_s       (above_s)
);

// File: tb/lvi_ctrl_tb.sv
module lvi_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cpu_en_i = 1'b0, osc_en_i = 1'b0;
  logic       below_fall_i = 1'b0, above_rise_i = 1'b0;
  logic       cfg_en_i = 1'b0, cfg_rst_en_i = 1'b0, cfg_stop_en_i = 1'b0, stop_i = 1'b0;
  logic       rst_req_o;
  logic [7:0] rd_data_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  lvi_ctrl u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic do_reset();
    cpu_en_i = 0; osc_en_i = 0; below_fall_i = 0; above_rise_i = 0;
    cfg_en_i = 0; cfg_rst_en_i = 0; cfg_stop_en_i = 0; stop_i = 0;
    rst_ni = 0;
    cyc(2);
    rst_ni = 1;
    cyc(1);
  endtask

  // change comparator levels with enables idle, then let the synchronizer settle
  task automatic set_cmp(input logic below, input logic above);
    cpu_en_i = 0; osc_en_i = 0;
    below_fall_i = below; above_rise_i = above;
    cyc(3);
  endtask

  task automatic pulse(input bit cpu, input bit osc, input int n);
    cpu_en_i = cpu; osc_en_i = osc;
    cyc(n);
    cpu_en_i = 0; osc_en_i = 0;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R6 reset rst_req", {7'd0, rst_req_o}, 8'd0);
    chk("R6 reset rd_data", rd_data_o, 8'h00);
  endtask

  task automatic t_cpu_filter();
    do_reset();
    cfg_en_i = 1; cfg_rst_en_i = 1;
    set_cmp(1, 0);
    pulse(1, 0, 8);
    chk("R1 eight cycles no reset", {7'd0, rst_req_o}, 8'd0);
    set_cmp(0, 0);
    pulse(1, 0, 1);          // count restart
    set_cmp(1, 0);
    pulse(1, 0, 8);
    chk("R1 restart after gap", {7'd0, rst_req_o}, 8'd0);
    pulse(1, 0, 1);
    chk("R1 ninth cycle reset", {7'd0, rst_req_o}, 8'd1);
    // R2 release needs a CPU cycle
    set_cmp(0, 1);
    chk("R2 held without cpu cycle", {7'd0, rst_req_o}, 8'd1);
    pulse(1, 0, 1);
    chk("R2 one cpu cycle releases", {7'd0, rst_req_o}, 8'd0);
  endtask

  task automatic t_osc_flag();
    do_reset();
    cfg_en_i = 1; cfg_rst_en_i = 1;
    set_cmp(1, 0);
    pulse(0, 1, 35);
    chk("R4 flag 0 after 35", rd_data_o, 8'h00);
    pulse(0, 1, 1);
    chk("R4 flag 1 at 36", rd_data_o, 8'h80);
    chk("R9 low bits zero", {1'b0, rd_data_o[6:0]}, 8'h00);
    set_cmp(0, 0);
    pulse(0, 1, 5);
    chk("R5 flag held between levels", rd_data_o, 8'h80);
    set_cmp(0, 1);           // no osc enable at all
    chk("R5 above clears flag", rd_data_o, 8'h00);
    set_cmp(1, 0);
    pulse(0, 1, 36);
    chk("R6 flag set before reset", rd_data_o, 8'h80);
    rst_ni = 0;
    #1;
    chk("R6 reset clears flag", rd_data_o, 8'h00);
    cyc(1);
    rst_ni = 1;
    cyc(1);
  endtask

  task automatic t_polled();
    do_reset();
    cfg_en_i = 1; cfg_rst_en_i = 0;
    set_cmp(1, 0);
    pulse(1, 1, 40);
    chk("R3 polled no reset", {7'd0, rst_req_o}, 8'd0);
    chk("R3 polled flag set", rd_data_o, 8'h80);
  endtask

  task automatic t_inactive();
    do_reset();
    cfg_en_i = 0; cfg_rst_en_i = 1;
    set_cmp(1, 0);
    pulse(1, 1, 40);
    chk("R8 disabled no reset", {7'd0, rst_req_o}, 8'd0);
    chk("R8 disabled no flag", rd_data_o, 8'h00);
    cfg_en_i = 1; stop_i = 1; cfg_stop_en_i = 0;
    pulse(1, 1, 40);
    chk("R8 stop inactive no flag", rd_data_o, 8'h00);
    chk("R8 stop inactive no reset", {7'd0, rst_req_o}, 8'd0);
  endtask

  task automatic t_stop_bypass();
    do_reset();
    cfg_en_i = 1; cfg_rst_en_i = 1; cfg_stop_en_i = 1; stop_i = 1;
    cyc(1);
    below_fall_i = 1;
    #1;
    chk("R7 bypass immediate", {7'd0, rst_req_o}, 8'd1);
    below_fall_i = 0;
    #1;
    chk("R7 bypass follows raw", {7'd0, rst_req_o}, 8'd0);
    cfg_stop_en_i = 0;
    below_fall_i = 1;
    #1;
    chk("R7 no bypass without stop enable", {7'd0, rst_req_o}, 8'd0);
    below_fall_i = 0;
    cyc(1);
  endtask

  task automatic t_coincide();
    do_reset();
    cfg_en_i = 1; cfg_rst_en_i = 1;
    set_cmp(1, 0);
    for (int k = 1; k <= 36; k++) begin
      osc_en_i = 1;
      cpu_en_i = (k % 4 == 0);
      cyc(1);
      if (k == 35) begin
        chk("R10 before edge rst", {7'd0, rst_req_o}, 8'd0);
        chk("R10 before edge flag", rd_data_o, 8'h00);
      end
    end
    osc_en_i = 0; cpu_en_i = 0;
    chk("R10 same edge rst", {7'd0, rst_req_o}, 8'd1);
    chk("R10 same edge flag", rd_data_o, 8'h80);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_cpu_filter();
    t_osc_flag();
    t_polled();
    t_inactive();
    t_stop_bypass();
    t_coincide();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule